// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed-BCD Arithmetic

This block is the purely combinational arithmetic and logic unit of a small accumulator machine. It takes two operands, a carry input, a decimal-arithmetic enable and a four-bit operation code. In the same cycle it returns a result, four condition flags (negative, overflow, zero, carry) and a four-bit write-enable that tells the surrounding register file which of those flags the operation is allowed to change.

Add and subtract have two modes. In binary mode they are ordinary two's-complement operations. In decimal mode they treat each four-bit digit as packed BCD and correct each digit on its own, with the digit carry or borrow rippling upward. The other operations are logic, shift and rotate, increment and decrement, a pass-through load, compare and a bit test. Each has its own rule for which flags it updates.

The flag write-enable and the flag outputs both use the bit order {N, V, Z, C}: bit 3 is N and bit 0 is C. A flag whose enable bit is clear always reads 0.

Top module: `alu8`

## Requirements
- R1: Code 0 (add), decimal off: result = (A + B + Cin) mod 256. C = carry out of bit 7. V = 1 when A and B share a sign bit and the result sign differs from it. N = result bit 7, Z = (result == 0). Write-enable = 1111.
- R2: Code 1 (subtract), decimal off: result = (A - B - (1 - Cin)) mod 256. C = 1 exactly when no borrow occurs. V = 1 when A and B differ in sign and the result sign differs from A. N and Z come from the result. Write-enable = 1111.
- R3: Code 0, decimal on: each digit, starting from the low one, sums A digit + B digit + incoming digit carry (Cin for the low digit). A sum above 9 gets 6 added. The digit carry out is 1 when the corrected sum exceeds 15, and the digit result is the low four bits. C = carry out of the top digit. Write-enable = 0001; N, V and Z read 0.
- R4: Code 1, decimal on: each digit computes A digit - B digit - incoming borrow (1 - Cin for the low digit) as a 5-bit value. When bit 4 of that value is set, the digit borrows and 6 is subtracted. C = NOT (borrow out of the top digit). Write-enable = 0001; N, V and Z read 0.
- R5: Codes 2 (OR), 3 (AND), 4 (XOR) and 13 (pass B): result is the logic function of A and B, or B itself for code 13. N = result bit 7, Z = (result == 0). Write-enable = 1010.
- R6: Codes 5 (shift left), 6 (shift right), 7 (rotate left), 8 (rotate right) act on A. The left forms put A bit 7 into C; the right forms put A bit 0 into C. The shifts fill with 0, rotate left fills bit 0 with Cin, and rotate right fills bit 7 with Cin. Write-enable = 1011.
- R7: Codes 9 (increment A) and 10 (decrement A) wrap modulo 256 (FF+1 = 00, 00-1 = FF). N and Z come from the result. Write-enable = 1010.
- R8: Code 11 (compare): result = A unchanged. C = (A >= B) unsigned, whatever Cin is. N and Z come from (A - B) mod 256. Write-enable = 1011.
- R9: Code 12 (bit test): result = A unchanged, N = B bit 7, V = B bit 6, Z = ((A AND B) == 0). Write-enable = 1110.
- R10: Codes 14 and 15 are unused: result = A, write-enable = 0000, all flags 0.
- R11: The decimal enable changes only codes 0 and 1. Every other code, compare included, gives the same outputs with it set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | Operand A (accumulator side) |
| opb | input | 8 | Operand B (memory or immediate side) |
| carry_in | input | 1 | Incoming carry; inverted borrow for subtract |
| bcd_en | input | 1 | Decimal arithmetic enable for add and subtract |
| op_sel | input | 4 | Operation code (see requirements) |
| result | output | 8 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_we | output | 4 | Flag write-enable, bits {N,V,Z,C} |

## Verification
The two functions that can meet in one evaluation are decimal correction and the non-arithmetic operations. The decimal enable is a separate input, so it can be high while a logic, shift or compare code is selected. Compare is the sharpest case, because it uses the same subtractor that decimal subtract uses. The bench therefore draws the decimal enable at random independently of the operation code on every vector, and adds directed compares with decimal on, including operands that are valid BCD. Each outcome is judged against a reference that only ever applies digit correction to codes 0 and 1.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_COUNT = 4;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_OR   = 4'd2,
        OP_AND  = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CMP  = 4'd11,
        OP_BIT  = 4'd12,
        OP_PASS = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flag_t;

    localparam flag_t WE_NVZC = 4'b1111;
    localparam flag_t WE_NVZ  = 4'b1110;
    localparam flag_t WE_NZC  = 4'b1011;
    localparam flag_t WE_NZ   = 4'b1010;
    localparam flag_t WE_C    = 4'b0001;
    localparam flag_t WE_NONE = 4'b0000;

    function automatic flag_t flag_enable(input alu_op_e op, input logic bcd);
        flag_t we;
        case (op)
            OP_ADC, OP_SBC:                 we = bcd ? WE_C : WE_NVZC;
            OP_OR, OP_AND, OP_XOR,
            OP_INC, OP_DEC, OP_PASS:        we = WE_NZ;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR,
            OP_CMP:                         we = WE_NZC;
            OP_BIT:                         we = WE_NVZ;
            default:                        we = WE_NONE;
        endcase
        return we;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    input  logic          bcd,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          ovf
);
    localparam int NIB = DW / 4;

    // binary path: subtract is A + ~B + Cin
    logic [DW-1:0] b_eff;
    logic [DW:0]   bin_sum;
    logic          bin_ovf;

    assign b_eff   = sub ? ~b : b;
    assign bin_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    assign bin_ovf = (a[DW-1] == b_eff[DW-1]) && (bin_sum[DW-1] != a[DW-1]);

    // decimal path: digit chain, dchain carries "carry" for add, "no borrow" for sub
    logic [NIB:0]  dchain;
    logic [DW-1:0] dec_res;

    assign dchain[0] = cin;

    for (genvar g = 0; g < NIB; g++) begin : g_digit
        logic [3:0] da, db;
        logic [5:0] s_raw, s_fix;
        logic [4:0] d_raw;
        logic [3:0] d_fix;

        assign da    = a[4*g +: 4];
        assign db    = b[4*g +: 4];
        assign s_raw = {2'b00, da} + {2'b00, db} + {5'b0, dchain[g]};
        assign s_fix = (s_raw > 6'd9) ? s_raw + 6'd6 : s_raw;
        assign d_raw = {1'b0, da} - {1'b0, db} - {4'b0, ~dchain[g]};
        assign d_fix = d_raw[4] ? d_raw[3:0] - 4'd6 : d_raw[3:0];

        assign dec_res[4*g +: 4] = sub ? d_fix : s_fix[3:0];
        assign dchain[g+1]       = sub ? ~d_raw[4] : (s_fix > 6'd15);
    end

    assign res  = bcd ? dec_res : bin_sum[DW-1:0];
    assign cout = bcd ? dchain[NIB] : bin_sum[DW];
    assign ovf  = bcd ? 1'b0 : bin_ovf;

    always_comb begin
        if (!bcd && !sub) begin
            // R1
            adc_sum_chk: assert ({cout, res} == ({1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin}));
        end
        if (!bcd && sub) begin
            // R2
            sbc_no_borrow_chk: assert (cout == ({1'b0, a} >= ({1'b0, b} + {{DW{1'b0}}, ~cin})));
        end
    end

endmodule

// File: rtl/alu8_shiftlogic.sv
module alu8_shiftlogic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  alu_op_e       op,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        res  = a;
        cout = 1'b0;
        case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_PASS: res = b;
            OP_INC:  res = a + {{(DW-1){1'b0}}, 1'b1};
            OP_DEC:  res = a - {{(DW-1){1'b0}}, 1'b1};
            OP_SHL:  begin res = {a[DW-2:0], 1'b0}; cout = a[DW-1]; end
            OP_SHR:  begin res = {1'b0, a[DW-1:1]}; cout = a[0];    end
            OP_ROL:  begin res = {a[DW-2:0], cin};  cout = a[DW-1]; end
            OP_ROR:  begin res = {cin, a[DW-1:1]};  cout = a[0];    end
            default: begin res = a; cout = 1'b0; end
        endcase
    end

endmodule

// File: rtl/alu8.sv
module alu8
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          carry_in,
    input  logic          bcd_en,
    input  logic [3:0]    op_sel,
    output logic [DW-1:0] result,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_z,
    output logic          flag_c,
    output logic [3:0]    flag_we
);
    alu_op_e op;
    logic    use_sub, use_bcd, use_cin;

    assign op      = alu_op_e'(op_sel);
    assign use_sub = (op == OP_SBC) || (op == OP_CMP);
    assign use_bcd = bcd_en && ((op == OP_ADC) || (op == OP_SBC));
    assign use_cin = (op == OP_CMP) ? 1'b1 : carry_in;

    logic [DW-1:0] as_res, sl_res;
    logic          as_cout, as_ovf, sl_cout;

    alu8_addsub #(.DW(DW)) i_addsub (
        .a    (opa),
        .b    (opb),
        .cin  (use_cin),
        .sub  (use_sub),
        .bcd  (use_bcd),
        .res  (as_res),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    alu8_shiftlogic #(.DW(DW)) i_shiftlogic (
        .a    (opa),
        .b    (opb),
        .cin  (carry_in),
        .op   (op),
        .res  (sl_res),
        .cout (sl_cout)
    );

    flag_t         raw, we;
    logic [DW-1:0] res_mux, nz_src;

    always_comb begin
        raw     = '0;
        res_mux = sl_res;
        nz_src  = sl_res;
        case (op)
            OP_ADC, OP_SBC: begin
                res_mux = as_res;
                nz_src  = as_res;
                raw.c   = as_cout;
                raw.v   = as_ovf;
            end
            OP_CMP: begin
                res_mux = opa;
                nz_src  = as_res;
                raw.c   = as_cout;
            end
            OP_BIT: begin
                res_mux = opa;
                nz_src  = opa;
                raw.v   = opb[DW-2];
            end
            default: raw.c = sl_cout;
        endcase
        raw.n = (op == OP_BIT) ? opb[DW-1] : nz_src[DW-1];
        raw.z = (op == OP_BIT) ? ((opa & opb) == '0) : (nz_src == '0);
        we    = flag_enable(op, bcd_en);
    end

    assign result  = res_mux;
    assign flag_we = we;
    assign flag_n  = raw.n & we.n;
    assign flag_v  = raw.v & we.v;
    assign flag_z  = raw.z & we.z;
    assign flag_c  = raw.c & we.c;

    always_comb begin
        if (op == OP_CMP) begin
            // R8
            cmp_carry_chk: assert (flag_c == (opa >= opb));
        end
        if (op == OP_BIT) begin
            // R9
            bit_keeps_a_chk: assert (result == opa);
        end
        if (flag_we[1] && op != OP_CMP && op != OP_BIT) begin
            // R5
            zero_flag_chk: assert (flag_z == (result == '0));
        end
    end

endmodule

// File: tb/test_alu8.sv
module test_alu8;

    logic       clk = 1'b0;
    logic [7:0] opa = '0, opb = '0;
    logic       carry_in = 1'b0, bcd_en = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c;
    logic [3:0] flag_we;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    alu8 i_alu8 (
        .opa(opa), .opb(opb), .carry_in(carry_in), .bcd_en(bcd_en),
        .op_sel(op_sel), .result(result), .flag_n(flag_n), .flag_v(flag_v),
        .flag_z(flag_z), .flag_c(flag_c), .flag_we(flag_we)
    );

    // expected {result[7:0], N, V, Z, C, we[3:0]}
    function automatic logic [15:0] model(input int a, input int b, input int cin,
                                          input int dec, input int op);
        int r, lo, hi, s, bl, bh;
        int n, v, z, c, m;
        r = a; n = 0; v = 0; z = 0; c = 0; m = 0;
        case (op)
            0: if (dec != 0) begin
                   lo = (a % 16) + (b % 16) + cin;
                   if (lo > 9) lo += 6;
                   hi = (a / 16) + (b / 16) + ((lo > 15) ? 1 : 0);
                   if (hi > 9) hi += 6;
                   c = (hi > 15) ? 1 : 0;
                   r = ((hi % 16) * 16) + (lo % 16);
                   m = 4'b0001;
               end else begin
                   s = a + b + cin;
                   r = s % 256;
                   c = (s > 255) ? 1 : 0;
                   v = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0;
                   m = 4'b1111;
               end
            1: if (dec != 0) begin
                   lo = (a % 16) - (b % 16) - (1 - cin);
                   bl = (lo < 0) ? 1 : 0;
                   if (bl != 0) lo -= 6;
                   hi = (a / 16) - (b / 16) - bl;
                   bh = (hi < 0) ? 1 : 0;
                   if (bh != 0) hi -= 6;
                   r = ((hi & 15) * 16) + (lo & 15);
                   c = 1 - bh;
                   m = 4'b0001;
               end else begin
                   s = a - b - (1 - cin);
                   c = (s >= 0) ? 1 : 0;
                   r = s & 255;
                   v = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                   m = 4'b1111;
               end
            2:  begin r = a | b; m = 4'b1010; end
            3:  begin r = a & b; m = 4'b1010; end
            4:  begin r = a ^ b; m = 4'b1010; end
            13: begin r = b;     m = 4'b1010; end
            5:  begin r = (a * 2) % 256;        c = a / 128; m = 4'b1011; end
            6:  begin r = a / 2;                c = a % 2;   m = 4'b1011; end
            7:  begin r = ((a * 2) % 256) + cin; c = a / 128; m = 4'b1011; end
            8:  begin r = (a / 2) + cin * 128;   c = a % 2;   m = 4'b1011; end
            9:  begin r = (a + 1) % 256;   m = 4'b1010; end
            10: begin r = (a + 255) % 256; m = 4'b1010; end
            11: begin
                    r = a;
                    c = (a >= b) ? 1 : 0;
                    s = (a - b) & 255;
                    n = s / 128;
                    z = (s == 0) ? 1 : 0;
                    m = 4'b1011;
                end
            12: begin
                    r = a;
                    n = (b / 128) % 2;
                    v = (b / 64) % 2;
                    z = ((a & b) == 0) ? 1 : 0;
                    m = 4'b1110;
                end
            default: begin r = a; m = 0; end
        endcase
        if (op != 11 && op != 12 && m[3]) begin
            n = r / 128;
            z = (r == 0) ? 1 : 0;
        end
        if (!m[3]) n = 0;
        if (!m[2]) v = 0;
        if (!m[1]) z = 0;
        if (!m[0]) c = 0;
        return {r[7:0], n[0], v[0], z[0], c[0], m[3:0]};
    endfunction

    function automatic string tag_for(input int op, input int dec);
        case (op)
            0:                 return (dec != 0) ? "R3" : "R1";
            1:                 return (dec != 0) ? "R4" : "R2";
            2, 3, 4, 13:       return "R5";
            5, 6, 7, 8:        return "R6";
            9, 10:             return "R7";
            11:                return "R8";
            12:                return "R9";
            default:           return "R10";
        endcase
    endfunction

    task automatic apply(input int a, input int b, input int cin, input int dec,
                         input int op, input string tag);
        logic [15:0] exp_v, got_v;
        @(negedge clk);
        opa = a[7:0]; opb = b[7:0]; carry_in = cin[0]; bcd_en = dec[0]; op_sel = op[3:0];
        #1;
        exp_v = model(a, b, cin, dec, op);
        got_v = {result, flag_n, flag_v, flag_z, flag_c, flag_we};
        n_checks++;
        if (got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h b=%02h cin=%0d dec=%0d got res=%02h nvzc=%04b we=%04b exp res=%02h nvzc=%04b we=%04b",
                     tag, op, a, b, cin, dec, got_v[15:8], got_v[7:4], got_v[3:0],
                     exp_v[15:8], exp_v[7:4], exp_v[3:0]);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int a, b, c, d, o;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);

        // idle inputs: add of zeros gives zero with Z set (R1)
        apply(8'h00, 8'h00, 0, 0, 0, "R1");
        // R1 signed overflow
        apply(8'h7F, 8'h01, 0, 0, 0, "R1");
        apply(8'hFF, 8'h01, 0, 0, 0, "R1");
        // R2 borrow and overflow
        apply(8'h80, 8'h01, 1, 0, 1, "R2");
        apply(8'h00, 8'h01, 1, 0, 1, "R2");
        apply(8'h05, 8'h05, 0, 0, 1, "R2");
        // R3 decimal add with digit carries
        apply(8'h58, 8'h46, 1, 1, 0, "R3");
        apply(8'h99, 8'h01, 0, 1, 0, "R3");
        apply(8'h50, 8'h50, 0, 1, 0, "R3");
        // R4 decimal subtract with borrow chain
        apply(8'h00, 8'h01, 1, 1, 1, "R4");
        apply(8'h10, 8'h01, 1, 1, 1, "R4");
        apply(8'h46, 8'h12, 0, 1, 1, "R4");
        // R6 rotate fill and shift out
        apply(8'h01, 8'h00, 1, 0, 8, "R6");
        apply(8'h80, 8'h00, 1, 0, 7, "R6");
        apply(8'h80, 8'h00, 1, 0, 5, "R6");
        apply(8'h01, 8'h00, 1, 0, 6, "R6");
        // R7 wrap
        apply(8'hFF, 8'h00, 0, 0, 9, "R7");
        apply(8'h00, 8'h00, 0, 0, 10, "R7");
        // R8 compare equality, less-than, carry input ignored
        apply(8'h42, 8'h42, 0, 0, 11, "R8");
        apply(8'h10, 8'h20, 1, 0, 11, "R8");
        // R9 bit test
        apply(8'h0F, 8'hC0, 0, 0, 12, "R9");
        apply(8'h01, 8'h41, 1, 0, 12, "R9");
        // R10 unused codes
        apply(8'h5A, 8'hFF, 1, 0, 14, "R10");
        apply(8'hA5, 8'h00, 0, 1, 15, "R10");
        // R11 decimal enable on non-arithmetic codes
        apply(8'h09, 8'h01, 0, 1, 11, "R11");
        apply(8'h15, 8'h27, 1, 1, 11, "R11");
        apply(8'h0F, 8'hF1, 0, 1, 2, "R11");
        apply(8'h99, 8'h00, 0, 1, 9, "R11");
        apply(8'h88, 8'h00, 1, 1, 7, "R11");

        for (int k = 0; k < 4000; k++) begin
            a = int'($urandom_range(0, 255));
            b = int'($urandom_range(0, 255));
            c = int'($urandom_range(0, 1));
            d = int'($urandom_range(0, 1));
            o = int'($urandom_range(0, 15));
            if (k % 4 == 0 && o < 2) begin
                a = (int'($urandom_range(0, 9)) * 16) + int'($urandom_range(0, 9));
                b = (int'($urandom_range(0, 9)) * 16) + int'($urandom_range(0, 9));
            end
            apply(a, b, c, d, o, (d != 0 && o > 1) ? "R11" : tag_for(o, d));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule